// File: doc/BRIEF.md
# Compression Transfer Status Tracker

This block sits beside a byte-stream compression or decompression engine. It keeps score of one transfer at a time. A control path starts a transfer and gives it a direction (compress or decompress) and a programmed length. From then on the block counts the bytes that cross the original-data side and the compressed-data side. The engine signals the end of the transfer with a completion pulse, and individual error causes arrive as one-cycle pulses. From these inputs the block keeps a busy flag, a done flag, sticky error bits and an expansion flag. The expansion flag is raised when a compression produced more output than input.

Both data sides are valid/ready handshakes that the block only observes. A byte counts in a cycle when valid and ready are both high. A cycle with valid high and ready low is back-pressure and counts nothing. The block never drives ready itself. When compressing, the original side carries bytes into the engine. When decompressing, it carries decompressed bytes out of the engine. A microprocessor reads the results through a three-bit byte address with combinational read data.

Top module: `xfer_status_tracker`

## Requirements
- R1: After hardware reset (rst_n low), every readable register reads zero except the engineering-level register. A synchronous sw_rst has the same clearing effect, and it wins over start in the same cycle.
- R2: A start pulse (without sw_rst) makes busy one in the next cycle. In that same cycle it clears both counts, the done flag, the expansion flag and the error bits, and it latches the mode (mode_decomp, 1 = decompress) and xfer_len.
- R3: While busy, the original-side count increases by one for each cycle in which orig_valid and orig_ready are both high, in either mode. Cycles with orig_ready low do not count.
- R4: In compress mode the original-side count stops at the latched length, and further original-side bytes are not counted. orig_full is high while busy, compressing and the count equals the length. In decompress mode there is no limit and orig_full stays low.
- R5: While busy, the compressed-side count increases by one for each cycle in which comp_valid and comp_ready are both high.
- R6: A finish pulse while busy, with no error pulse in that cycle, clears busy and sets done in the next cycle. A finish pulse while not busy has no effect.
- R7: On a finish that completes a compression, the expansion flag is set exactly when the compressed count is strictly greater than the original count. Both counts are taken as they stood before that cycle. A decompression never sets the flag.
- R8: Each bit of err_pulse sets the matching sticky error bit. The bit holds until start, sw_rst or reset. Any error pulse clears busy in the next cycle. Any-error is the OR of all the error bits.
- R9: Read map on rd_addr:
  - address 0: status, with busy at bit 7, expansion at bit 3, any-error at bit 1 and done at bit 0. Bits 6:4 and bit 2 read zero.
  - address 1: the constant 0xEC.
  - addresses 2 and 3: the original count, high byte then low byte.
  - addresses 4 and 5: the compressed count, high byte then low byte.
  - address 6: the error bits.
  - address 7: zero.
- R10: While not busy, handshakes on either data side leave both counts unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| sw_rst | input | 1 | Synchronous software reset |
| start | input | 1 | Begin a new transfer |
| mode_decomp | input | 1 | Direction sampled at start: 0 compress, 1 decompress |
| xfer_len | input | CNT_W | Programmed transfer length sampled at start |
| orig_valid | input | 1 | Original-side handshake valid |
| orig_ready | input | 1 | Original-side handshake ready |
| comp_valid | input | 1 | Compressed-side handshake valid |
| comp_ready | input | 1 | Compressed-side handshake ready |
| finish | input | 1 | Engine completion pulse |
| err_pulse | input | ERR_W | One pulse line per error cause |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| orig_full | output | 1 | All programmed input bytes received (compress mode) |

## Verification
Every flag and count is a register loaded on the clock edge that samples the stimulus. Its effect therefore appears one cycle after a start, finish, error or handshake cycle. Read data and orig_full are combinational from those registers. The bench drives inputs on the falling edge and holds each handshake for a full cycle. It reads registers only on a later falling edge plus a small delay, so it always sees the value registered one cycle after the stimulus. For expansion, the bench issues finish only after the last handshake has been registered, so the compared counts are the final ones.

// File: rtl/xst_pkg.sv
package xst_pkg;
  localparam logic [7:0] EC_LEVEL = 8'hEC;

  typedef enum logic [2:0] {
    A_STATUS = 3'd0,
    A_ECL    = 3'd1,
    A_OHI    = 3'd2,
    A_OLO    = 3'd3,
    A_CHI    = 3'd4,
    A_CLO    = 3'd5,
    A_ERR    = 3'd6,
    A_NONE   = 3'd7
  } reg_addr_e;

  localparam int B_BUSY   = 7;
  localparam int B_EXP    = 3;
  localparam int B_ANYERR = 1;
  localparam int B_DONE   = 0;
endpackage

// File: rtl/xst_counter.sv
module xst_counter #(
  parameter int W         = 16,
  parameter bit HAS_LIMIT = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  input  logic         lim_en,
  input  logic [W-1:0] lim,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] MAXV = '1;

  logic at_lim;

  generate
    if (HAS_LIMIT) begin : g_lim
      assign at_lim = lim_en && (cnt == lim);
    end else begin : g_nolim
      logic unused_lim;
      assign unused_lim = lim_en ^ (^lim);
      assign at_lim     = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (clr)
      cnt <= '0;
    else if (inc && !at_lim && cnt != MAXV)
      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/xst_status_ctl.sv
module xst_status_ctl #(
  parameter int CNT_W = 16,
  parameter int ERR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_rst,
  input  logic             start,
  input  logic             mode_decomp,
  input  logic [CNT_W-1:0] xfer_len,
  input  logic             finish,
  input  logic [ERR_W-1:0] err_pulse,
  input  logic [CNT_W-1:0] orig_cnt,
  input  logic [CNT_W-1:0] comp_cnt,
  output logic             busy,
  output logic             done,
  output logic             expd,
  output logic [ERR_W-1:0] err_q,
  output logic             mode_q,
  output logic [CNT_W-1:0] len_q
);
  logic any_pulse;
  assign any_pulse = |err_pulse;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      expd   <= 1'b0;
      err_q  <= '0;
      mode_q <= 1'b0;
      len_q  <= '0;
    end else if (sw_rst) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      expd   <= 1'b0;
      err_q  <= '0;
      mode_q <= 1'b0;
      len_q  <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      done   <= 1'b0;
      expd   <= 1'b0;
      err_q  <= '0;
      mode_q <= mode_decomp;
      len_q  <= xfer_len;
    end else begin
      err_q <= err_q | err_pulse;
      if (any_pulse) begin
        busy <= 1'b0;
      end else if (finish && busy) begin
        busy <= 1'b0;
        done <= 1'b1;
        expd <= !mode_q && (comp_cnt > orig_cnt);
      end
    end
  end
endmodule

// File: rtl/xst_reg_mux.sv
module xst_reg_mux
  import xst_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int ERR_W = 8
) (
  input  logic [2:0]       rd_addr,
  input  logic             busy,
  input  logic             done,
  input  logic             expd,
  input  logic [ERR_W-1:0] err_q,
  input  logic [CNT_W-1:0] orig_cnt,
  input  logic [CNT_W-1:0] comp_cnt,
  output logic [7:0]       rd_data
);
  logic [15:0] o16, c16;
  logic [7:0]  e8, stat;

  assign o16 = 16'(orig_cnt);
  assign c16 = 16'(comp_cnt);
  assign e8  = 8'(err_q);

  always_comb begin
    stat           = '0;
    stat[B_BUSY]   = busy;
    stat[B_EXP]    = expd;
    stat[B_ANYERR] = |err_q;
    stat[B_DONE]   = done;
  end

  always_comb begin
    case (reg_addr_e'(rd_addr))
      A_STATUS: rd_data = stat;
      A_ECL:    rd_data = EC_LEVEL;
      A_OHI:    rd_data = o16[15:8];
      A_OLO:    rd_data = o16[7:0];
      A_CHI:    rd_data = c16[15:8];
      A_CLO:    rd_data = c16[7:0];
      A_ERR:    rd_data = e8;
      default:  rd_data = 8'h00;
    endcase
  end
endmodule

// File: rtl/xfer_status_tracker.sv
module xfer_status_tracker #(
  parameter int CNT_W = 16,
  parameter int ERR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_rst,
  input  logic             start,
  input  logic             mode_decomp,
  input  logic [CNT_W-1:0] xfer_len,
  input  logic             orig_valid,
  input  logic             orig_ready,
  input  logic             comp_valid,
  input  logic             comp_ready,
  input  logic             finish,
  input  logic [ERR_W-1:0] err_pulse,
  input  logic [2:0]       rd_addr,
  output logic [7:0]       rd_data,
  output logic             orig_full
);
  logic             busy, done, expd, mode_q;
  logic [ERR_W-1:0] err_q;
  logic [CNT_W-1:0] len_q, orig_cnt, comp_cnt;
  logic             cnt_clr, orig_inc, comp_inc;

  assign cnt_clr  = sw_rst || start;
  assign orig_inc = busy && orig_valid && orig_ready;
  assign comp_inc = busy && comp_valid && comp_ready;

  xst_counter #(.W(CNT_W), .HAS_LIMIT(1'b1)) u_orig_cnt (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(orig_inc),
    .lim_en(!mode_q), .lim(len_q), .cnt(orig_cnt)
  );

  xst_counter #(.W(CNT_W), .HAS_LIMIT(1'b0)) u_comp_cnt (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(comp_inc),
    .lim_en(1'b0), .lim(len_q), .cnt(comp_cnt)
  );

  xst_status_ctl #(.CNT_W(CNT_W), .ERR_W(ERR_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .start(start),
    .mode_decomp(mode_decomp), .xfer_len(xfer_len), .finish(finish),
    .err_pulse(err_pulse), .orig_cnt(orig_cnt), .comp_cnt(comp_cnt),
    .busy(busy), .done(done), .expd(expd), .err_q(err_q),
    .mode_q(mode_q), .len_q(len_q)
  );

  xst_reg_mux #(.CNT_W(CNT_W), .ERR_W(ERR_W)) u_mux (
    .rd_addr(rd_addr), .busy(busy), .done(done), .expd(expd),
    .err_q(err_q), .orig_cnt(orig_cnt), .comp_cnt(comp_cnt),
    .rd_data(rd_data)
  );

  assign orig_full = busy && !mode_q && (orig_cnt == len_q);
endmodule

// File: rtl/xfer_status_tracker_chk.sv
module xfer_status_tracker_chk #(
  parameter int CNT_W = 16,
  parameter int ERR_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sw_rst,
  input logic             start,
  input logic             finish,
  input logic [ERR_W-1:0] err_pulse,
  input logic             busy,
  input logic             done,
  input logic             expd,
  input logic [ERR_W-1:0] err_q,
  input logic             mode_q,
  input logic [CNT_W-1:0] len_q,
  input logic [CNT_W-1:0] orig_cnt,
  input logic [CNT_W-1:0] comp_cnt,
  input logic [2:0]       rd_addr,
  input logic [7:0]       rd_data
);
  assert_sw_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |=> (orig_cnt == '0 && comp_cnt == '0 && !busy && err_q == '0));

  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !sw_rst) |=> (busy && !done && orig_cnt == '0));

  assert_len_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mode_q) |-> (orig_cnt <= len_q));

  assert_finish_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && busy && !start && !sw_rst && err_pulse == '0) |=> (done && !busy));

  assert_no_decomp_exp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q |-> !expd);

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !sw_rst) |=> ((err_q & $past(err_q)) == $past(err_q)));

  assert_err_stops_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((|err_pulse) && !start && !sw_rst) |=> !busy);

  assert_ecl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == 3'd1) |-> (rd_data == 8'hEC));

  assert_reserved_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == 3'd0) |-> (rd_data[6:4] == 3'b000 && !rd_data[2]));
endmodule

bind xfer_status_tracker xfer_status_tracker_chk #(.CNT_W(CNT_W), .ERR_W(ERR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .start(start), .finish(finish),
  .err_pulse(err_pulse), .busy(busy), .done(done), .expd(expd), .err_q(err_q),
  .mode_q(mode_q), .len_q(len_q), .orig_cnt(orig_cnt), .comp_cnt(comp_cnt),
  .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/xfer_status_tracker_tb_top.sv
module xfer_status_tracker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sw_rst = 1'b0, start = 1'b0, mode_decomp = 1'b0;
  logic [15:0] xfer_len = '0;
  logic        orig_valid = 1'b0, orig_ready = 1'b0;
  logic        comp_valid = 1'b0, comp_ready = 1'b0;
  logic        finish = 1'b0;
  logic [7:0]  err_pulse = '0;
  logic [2:0]  rd_addr = '0;
  logic [7:0]  rd_data;
  logic        orig_full;

  int checks = 0, errors = 0;
  bit ended = 0;

  always #5 clk = ~clk;

  xfer_status_tracker dut_i (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .start(start),
    .mode_decomp(mode_decomp), .xfer_len(xfer_len),
    .orig_valid(orig_valid), .orig_ready(orig_ready),
    .comp_valid(comp_valid), .comp_ready(comp_ready),
    .finish(finish), .err_pulse(err_pulse), .rd_addr(rd_addr),
    .rd_data(rd_data), .orig_full(orig_full)
  );

  // {mode, len, n_orig, n_comp, exp_orig, exp_comp, exp_expansion}
  localparam int NV = 5;
  localparam logic [65:0] VEC [NV] = '{
    {1'b0, 16'd10, 8'd10, 8'd6, 16'd10, 16'd6, 1'b0},
    {1'b0, 16'd5,  8'd5,  8'd8, 16'd5,  16'd8, 1'b1},
    {1'b0, 16'd4,  8'd7,  8'd4, 16'd4,  16'd4, 1'b0},
    {1'b1, 16'd3,  8'd6,  8'd9, 16'd6,  16'd9, 1'b0},
    {1'b0, 16'd0,  8'd3,  8'd1, 16'd0,  16'd1, 1'b1}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic rd16(input logic [2:0] hi, output logic [15:0] d);
    logic [7:0] h, l;
    rd(hi, h);
    rd(hi + 3'd1, l);
    d = {h, l};
  endtask

  task automatic pulse_start(input logic m, input logic [15:0] len);
    @(negedge clk);
    start = 1'b1; mode_decomp = m; xfer_len = len;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic pulse_finish();
    @(negedge clk); finish = 1'b1;
    @(negedge clk); finish = 1'b0;
  endtask

  task automatic pulse_err(input logic [7:0] e);
    @(negedge clk); err_pulse = e;
    @(negedge clk); err_pulse = '0;
  endtask

  task automatic orig_bytes(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); orig_valid = 1'b1; orig_ready = 1'b0;
      @(negedge clk); orig_ready = 1'b1;
    end
    @(negedge clk); orig_valid = 1'b0; orig_ready = 1'b0;
  endtask

  task automatic comp_bytes(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); comp_valid = 1'b1; comp_ready = 1'b1;
    end
    @(negedge clk); comp_valid = 1'b0; comp_ready = 1'b0;
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [7:0]  d8;
    logic [15:0] d16;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state across the whole map
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d8);
      check("R1/R9 reset read", {8'h0, d8}, (a == 1) ? 16'h00EC : 16'h0000);
    end

    // Vector table: R2..R7, R9
    for (int i = 0; i < NV; i++) begin
      logic [65:0] v;
      v = VEC[i];
      pulse_start(v[65], v[64:49]);
      rd(3'd0, d8);
      check("R2 busy after start", {8'h0, d8}, 16'h0080);
      orig_bytes(int'(v[48:41]));
      comp_bytes(int'(v[40:33]));
      #1;
      check("R4 orig_full", {15'h0, orig_full}, {15'h0, !v[65]});
      pulse_finish();
      rd(3'd0, d8);
      check("R6/R7 status after finish", {8'h0, d8}, {8'h0, 4'h0, v[0], 3'b001});
      rd16(3'd2, d16);
      check("R3/R4 orig count", d16, v[32:17]);
      rd16(3'd4, d16);
      check("R5 comp count", d16, v[16:1]);
    end

    // R10: idle handshakes ignored (last vector: orig 0, comp 1)
    orig_bytes(3);
    comp_bytes(3);
    rd16(3'd2, d16);
    check("R10 idle orig count", d16, 16'd0);
    rd16(3'd4, d16);
    check("R10 idle comp count", d16, 16'd1);

    // R8: errors
    pulse_start(1'b0, 16'd20);
    orig_bytes(2);
    pulse_err(8'h05);
    rd(3'd0, d8);
    check("R8 error clears busy", {8'h0, d8}, 16'h0002);
    pulse_err(8'h80);
    rd(3'd6, d8);
    check("R8 sticky error bits", {8'h0, d8}, 16'h0085);
    pulse_finish();
    rd(3'd0, d8);
    check("R6 finish when idle ignored", {8'h0, d8}, 16'h0002);
    rd16(3'd2, d16);
    check("R3 count held after error", d16, 16'd2);
    pulse_start(1'b1, 16'd9);
    rd(3'd6, d8);
    check("R2 start clears errors", {8'h0, d8}, 16'h0000);
    rd(3'd0, d8);
    check("R2 status after restart", {8'h0, d8}, 16'h0080);
    rd16(3'd2, d16);
    check("R2 count cleared", d16, 16'd0);
    #1;
    check("R4 orig_full low in decompress", {15'h0, orig_full}, 16'h0);

    // R1: software reset wins over start
    orig_bytes(3);
    comp_bytes(2);
    @(negedge clk); sw_rst = 1'b1; start = 1'b1;
    @(negedge clk); sw_rst = 1'b0; start = 1'b0;
    rd(3'd0, d8);
    check("R1 sw_rst beats start", {8'h0, d8}, 16'h0000);
    rd16(3'd2, d16);
    check("R1 sw_rst orig count", d16, 16'd0);
    rd16(3'd4, d16);
    check("R1 sw_rst comp count", d16, 16'd0);
    rd(3'd7, d8);
    check("R9 unused address", {8'h0, d8}, 16'h0000);

    // R1: hardware reset mid-transfer
    pulse_start(1'b0, 16'd8);
    orig_bytes(2);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd16(3'd2, d16);
    check("R1 hw reset count", d16, 16'd0);
    rd(3'd1, d8);
    check("R9 engineering level", {8'h0, d8}, 16'h00EC);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule